// File: doc/BRIEF.md
# Self-Timed Word Reprogramming Sequencer

This block owns a nonvolatile-style storage array of 1024 bytes and runs the self-timed reprogramming of one word at a time. A program request carries a word address and a data byte. The block then runs up to two timed phases. The erase phase turns every bit of the word to one. The write phase then clears the bits that are zero in the data byte. A phase is left out when it would change nothing, which shortens the cycle. The phase lengths are parameters counted in system clocks. The defaults assume a 50 MHz clock: 5 ms per phase and 20 ms for a whole-array erase.

The bus protocol engine in front of the block issues the request when it sees the closing stop condition. It watches `busy` to answer polls for the end of programming, and it may cut a running cycle short with an abort strobe. A special case turns one request into a whole-array erase: the test input is high, the address is 0 and the data is 0xFF. After a timed interval the array is swept to all ones, one word per clock. The protocol engine reads stored bytes through a registered read port.

Top module: `eeprom_prog_seq`

## Requirements
- R1: After reset `busy` is 0 and every word of the array reads 0xFF.
- R2: A request whose target word is not 0xFF and whose data is not 0xFF runs an erase phase and then a write phase. `busy` stays high for ERASE_CYC + WRITE_CYC clocks, and the word then reads the request data.
- R3: A request with data 0xFF whose target word is not 0xFF runs only the erase phase. `busy` stays high for ERASE_CYC clocks, and the word then reads 0xFF.
- R4: A request whose target word already reads 0xFF skips the erase phase and runs only the write phase. `busy` stays high for WRITE_CYC clocks, and the word then reads the request data.
- R5: A request with data 0xFF whose target word already reads 0xFF needs no phase. `busy` never rises and the word stays 0xFF.
- R6: An abort while an erase phase runs drops `busy` at the next clock edge and leaves the target word at its old value.
- R7: An abort while a write phase runs drops `busy` at the next clock edge and leaves the target word at 0xFF.
- R8: A request with the test input high, address 0 and data 0xFF erases the whole array. `busy` stays high for BULK_CYC + 1024 clocks, and every word then reads 0xFF.
- R9: With the test input high, any other address or data is treated as an ordinary single-word request.
- R10: A request that arrives while `busy` is high is ignored. The running cycle keeps its length and the other word is not changed.
- R11: `rd_data` shows the word at `rd_addr` one clock after the address is presented.
- R12: An abort in the same clock as the end of a phase takes priority. That phase commits nothing and `busy` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | One-clock program request strobe |
| req_addr | input | 10 | Word address of the request |
| req_data | input | 8 | Data byte of the request |
| bulk_en | input | 1 | Test input that permits the whole-array erase |
| abort | input | 1 | Strobe that ends a running cycle |
| busy | output | 1 | High while a programming cycle runs |
| rd_addr | input | 10 | Read port word address |
| rd_data | output | 8 | Registered read port data |

## Verification
Two events can fall in the same clock: the abort strobe and the expiry of a phase timer. The bench provokes this by raising abort exactly ERASE_CYC clocks after the request, when the erase timer runs out. It then judges priority at the ports: `busy` must fall at that edge, and reading the word back must still give its old value, not 0xFF. A request sent part-way through a running cycle is the second overlap. It is judged by the unchanged cycle length and by the untouched second word.

// File: rtl/eeprom_seq_pkg.sv
// Package: shared phase encoding for the reprogramming sequencer.
// Assumes: imported by the controller only; the encoding is internal.
package eeprom_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ERASE = 3'd1,
        PH_WRITE = 3'd2,
        PH_BULK  = 3'd3,
        PH_SWEEP = 3'd4
    } prog_phase_t;

endpackage

// File: rtl/eeprom_phase_timer.sv
// Module: down counter that times one phase.
// Loading value N makes expire high exactly N clocks later.
// Assumes: N >= 1; expire stays high while idle at zero, and the
// controller ignores it outside timed phases.
module eeprom_phase_timer #(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expire
);

    logic [TW-1:0] cnt_q;

    // Count down from the loaded length, stopping at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - TW'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign expire = (cnt_q == '0);

endmodule

// File: rtl/eeprom_word_array.sv
// Module: byte-wide storage array with one write port, one
// combinational probe port for the controller and one registered
// read port for the protocol engine.
// Assumes: reset models a fresh array with every word erased to ones.
module eeprom_word_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic [DATA_W-1:0] probe_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one word per clock; the read port registers its word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
            rd_data <= '1;
        end else begin
            if (we) begin
                mem[waddr] <= wdata;
            end
            rd_data <= mem[rd_addr];
        end
    end

    assign probe_data = mem[probe_addr];

endmodule

// File: rtl/eeprom_seq_ctrl.sv
// Module: phase controller. It decides at request time which phases
// are needed, commits each phase's result at the end of the phase,
// and sweeps the array for a whole-array erase.
// Assumes: probe_data is the current content of the word at req_addr;
// abort has priority over any commit in the same clock.
module eeprom_seq_ctrl
    import eeprom_seq_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 8,
    parameter int TW        = 20,
    parameter int ERASE_CYC = 250_000,
    parameter int WRITE_CYC = 250_000,
    parameter int BULK_CYC  = 1_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              bulk_en,
    input  logic              abort,
    input  logic [DATA_W-1:0] probe_data,
    input  logic              expire,
    output logic              tmr_load,
    output logic [TW-1:0]     tmr_val,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy
);

    localparam logic [DATA_W-1:0] ONES      = '1;
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
    localparam logic [TW-1:0]     T_ERASE   = TW'(ERASE_CYC);
    localparam logic [TW-1:0]     T_WRITE   = TW'(WRITE_CYC);
    localparam logic [TW-1:0]     T_BULK    = TW'(BULK_CYC);

    prog_phase_t       phase_q, phase_d;
    logic [ADDR_W-1:0] tgt_addr_q;
    logic [DATA_W-1:0] tgt_data_q;
    logic [ADDR_W-1:0] sweep_q;
    logic              bulk_hit;

    assign bulk_hit = bulk_en && (req_addr == '0) && (req_data == ONES);

    // Next phase, timer loads and array commits.
    always_comb begin
        phase_d   = phase_q;
        tmr_load  = 1'b0;
        tmr_val   = T_ERASE;
        mem_we    = 1'b0;
        mem_waddr = tgt_addr_q;
        mem_wdata = ONES;
        unique case (phase_q)
            PH_IDLE: begin
                if (req) begin
                    if (bulk_hit) begin
                        phase_d  = PH_BULK;
                        tmr_load = 1'b1;
                        tmr_val  = T_BULK;
                    end else if (probe_data != ONES) begin
                        phase_d  = PH_ERASE;
                        tmr_load = 1'b1;
                        tmr_val  = T_ERASE;
                    end else if (req_data != ONES) begin
                        phase_d  = PH_WRITE;
                        tmr_load = 1'b1;
                        tmr_val  = T_WRITE;
                    end
                end
            end
            PH_ERASE: begin
                if (abort) begin
                    phase_d = PH_IDLE;
                end else if (expire) begin
                    mem_we = 1'b1;
                    if (tgt_data_q != ONES) begin
                        phase_d  = PH_WRITE;
                        tmr_load = 1'b1;
                        tmr_val  = T_WRITE;
                    end else begin
                        phase_d = PH_IDLE;
                    end
                end
            end
            PH_WRITE: begin
                if (abort) begin
                    phase_d = PH_IDLE;
                end else if (expire) begin
                    mem_we    = 1'b1;
                    mem_wdata = tgt_data_q;
                    phase_d   = PH_IDLE;
                end
            end
            PH_BULK: begin
                if (abort) begin
                    phase_d = PH_IDLE;
                end else if (expire) begin
                    phase_d = PH_SWEEP;
                end
            end
            PH_SWEEP: begin
                if (abort) begin
                    phase_d = PH_IDLE;
                end else begin
                    mem_we    = 1'b1;
                    mem_waddr = sweep_q;
                    if (sweep_q == LAST_ADDR) begin
                        phase_d = PH_IDLE;
                    end
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            tgt_addr_q <= '0;
            tgt_data_q <= '1;
        end else begin
            phase_q <= phase_d;
            if (phase_q == PH_IDLE && req) begin
                tgt_addr_q <= req_addr;
                tgt_data_q <= req_data;
            end
        end
    end

    // Sweep address: restarts at zero outside the sweep.
    always_ff @(posedge clk) begin
        if (!rst_n || phase_q != PH_SWEEP) begin
            sweep_q <= '0;
        end else begin
            sweep_q <= sweep_q + ADDR_W'(1);
        end
    end

    assign busy = (phase_q != PH_IDLE);

endmodule

// File: rtl/eeprom_prog_seq.sv
// Module: top of the self-timed reprogramming sequencer. It joins the
// phase controller, the phase timer and the storage array.
// Assumes: req is a one-clock strobe from the protocol engine; every
// phase length is at least one clock.
module eeprom_prog_seq #(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 8,
    parameter int ERASE_CYC = 250_000,
    parameter int WRITE_CYC = 250_000,
    parameter int BULK_CYC  = 1_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              bulk_en,
    input  logic              abort,
    output logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int MAX_EW  = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
    localparam int MAX_CYC = (MAX_EW > BULK_CYC) ? MAX_EW : BULK_CYC;
    localparam int TW      = $clog2(MAX_CYC + 1);

    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              expire;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] probe_data;

    eeprom_seq_ctrl #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .TW       (TW),
        .ERASE_CYC(ERASE_CYC),
        .WRITE_CYC(WRITE_CYC),
        .BULK_CYC (BULK_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .bulk_en   (bulk_en),
        .abort     (abort),
        .probe_data(probe_data),
        .expire    (expire),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .busy      (busy)
    );

    eeprom_phase_timer #(
        .TW(TW)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expire  (expire)
    );

    eeprom_word_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (mem_we),
        .waddr     (mem_waddr),
        .wdata     (mem_wdata),
        .probe_addr(req_addr),
        .probe_data(probe_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/eeprom_seq_chk.sv
// Module: property checker bound to the sequencer top. It watches the
// ports and the array write strobe.
// Assumes: synchronous active-low reset; all checks are off in reset.
module eeprom_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic abort,
    input logic busy,
    input logic mem_we
);

    // R6: an abort while busy ends the cycle at the next edge.
    p_abort_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> !busy);

    // R10: a cycle only starts from a request.
    p_start_from_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req));

    // R5: the array is only written while a cycle runs.
    p_store_when_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R12: an abort suppresses any commit in its clock.
    p_abort_no_store_r12: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> !mem_we);

endmodule

bind eeprom_prog_seq eeprom_seq_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .abort (abort),
    .busy  (busy),
    .mem_we(mem_we)
);

// File: tb/sim_eeprom_prog_seq.sv
// Bench: a vector table of single-word requests, then directed tests
// for reset, whole-array erase, aborts, overlap and ignored requests.
module sim_eeprom_prog_seq;

    localparam int ERASE_N = 16;
    localparam int WRITE_N = 12;
    localparam int BULK_N  = 40;
    localparam int DEPTH   = 1024;

    // Kind codes: 0 no phase, 1 write only, 2 erase only, 3 both.
    // Fields: bulk[28], addr[27:18], data[17:10], kind[9:8], word[7:0].
    localparam int NV = 8;
    localparam logic [28:0] VEC [NV] = '{
        {1'b0, 10'd5,    8'h3C, 2'd1, 8'h3C},
        {1'b0, 10'd5,    8'hA5, 2'd3, 8'hA5},
        {1'b0, 10'd5,    8'hFF, 2'd2, 8'hFF},
        {1'b0, 10'd5,    8'hFF, 2'd0, 8'hFF},
        {1'b0, 10'd1023, 8'h00, 2'd1, 8'h00},
        {1'b0, 10'd1023, 8'h7E, 2'd3, 8'h7E},
        {1'b1, 10'd7,    8'hFF, 2'd0, 8'hFF},
        {1'b1, 10'd0,    8'h11, 2'd1, 8'h11}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic [9:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic       bulk_en = 1'b0;
    logic       abort = 1'b0;
    logic       busy;
    logic [9:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    eeprom_prog_seq #(
        .ERASE_CYC(ERASE_N),
        .WRITE_CYC(WRITE_N),
        .BULK_CYC (BULK_N)
    ) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .req_addr(req_addr),
        .req_data(req_data),
        .bulk_en (bulk_en),
        .abort   (abort),
        .busy    (busy),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    function automatic int kind_len(input logic [1:0] k);
        case (k)
            2'd1:    return WRITE_N;
            2'd2:    return ERASE_N;
            2'd3:    return ERASE_N + WRITE_N;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Pulse a request for one clock; returns at the negedge after it.
    task automatic start_req(input logic b, input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        req = 1'b1; req_addr = a; req_data = d; bulk_en = b;
        @(negedge clk);
        req = 1'b0; bulk_en = 1'b0;
    endtask

    // Count clocks of busy after the request.
    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic read_word(input logic [9:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        @(negedge clk);
        d = rd_data;
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        check("R1 busy", busy, 0);
        read_word(10'd0, d);    check("R1 word0", d, 8'hFF);
        read_word(10'd1023, d); check("R1 word1023 R11", d, 8'hFF);

        // Table: R2, R3, R4, R5, R9, R11.
        for (int i = 0; i < NV; i++) begin
            start_req(VEC[i][28], VEC[i][27:18], VEC[i][17:10]);
            wait_idle(n);
            check($sformatf("R2/R3/R4/R5/R9 len vec%0d", i), n, kind_len(VEC[i][9:8]));
            read_word(VEC[i][27:18], d);
            check($sformatf("R2/R3/R4/R5/R9 R11 word vec%0d", i), d, VEC[i][7:0]);
        end

        // R8: whole-array erase.
        start_req(1'b1, 10'd0, 8'hFF);
        wait_idle(n);
        check("R8 len", n, BULK_N + DEPTH);
        read_word(10'd0, d);    check("R8 word0", d, 8'hFF);
        read_word(10'd1023, d); check("R8 word1023", d, 8'hFF);
        read_word(10'd512, d);  check("R8 word512", d, 8'hFF);

        // R6: abort during erase leaves the old value.
        start_req(1'b0, 10'd20, 8'h00);
        wait_idle(n);
        start_req(1'b0, 10'd20, 8'h0F);
        repeat (5) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check("R6 busy", busy, 0);
        read_word(10'd20, d); check("R6 word", d, 8'h00);

        // R7: abort during write leaves the erased value.
        start_req(1'b0, 10'd20, 8'h0F);
        repeat (ERASE_N + 3) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check("R7 busy", busy, 0);
        read_word(10'd20, d); check("R7 word", d, 8'hFF);

        // R12: abort in the clock the erase timer runs out.
        start_req(1'b0, 10'd20, 8'h00);
        wait_idle(n);
        start_req(1'b0, 10'd20, 8'h0F);
        repeat (ERASE_N - 1) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check("R12 busy", busy, 0);
        read_word(10'd20, d); check("R12 word", d, 8'h00);

        // R10: a request during a running cycle is ignored.
        start_req(1'b0, 10'd30, 8'h55);
        repeat (3) @(negedge clk);
        req = 1'b1; req_addr = 10'd31; req_data = 8'h00;
        @(negedge clk);
        req = 1'b0;
        wait_idle(n);
        check("R10 len", n + 4, WRITE_N);
        read_word(10'd30, d); check("R10 word30", d, 8'h55);
        read_word(10'd31, d); check("R10 word31", d, 8'hFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule